// File: doc/BRIEF.md
# ALU status flag register

This block pairs an 8-bit arithmetic and logic unit with the five-flag status register that records the outcome of each operation. Every enabled cycle it takes an operation code, an accumulator operand and a data operand. It then registers the result and updates the negative, overflow, zero, digit-carry and carry flags that the operation is defined to affect. The unit can add, subtract, perform AND, OR and XOR, clear, rotate through carry, set or clear one bit, swap nibbles and move a value.

The status register is also an ordinary data location. When the destination select is high, the status value replaces the data operand as the source, and the result is written back into it. If the operation affects any flag, the flag logic keeps control of all five flag bits and no data reaches them. Operations that leave flags alone write the status bits exactly as data. The upper three bits are not implemented: they always read 0.

Top module: `alu_status_unit`

## Requirements
- R1: After reset `result_o` is 0. `status_o[7:5]` reads 0 at all times, whatever value is written.
- R2: The flag bits sit at N=bit 4, OV=bit 3, Z=bit 2, DC=bit 1 and C=bit 0. Move (code 11) puts `acc_i` on the result and changes no flag. When it targets the status register, it loads `acc_i[4:0]` into the flags.
- R3: Add (code 0) gives (f + acc) mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3. OV is set when the signed sum falls outside -128..127. Z is set for a zero result and N copies result bit 7.
- R4: Subtract (code 1) gives (f - acc) mod 256. C=1 when f >= acc and DC=1 when f[3:0] >= acc[3:0], so both hold inverted borrow. OV is set when the signed difference falls outside -128..127. Z and N follow the result.
- R5: AND (code 2), OR (code 3) and XOR (code 4) of f and acc update only Z and N. C, DC and OV keep their values.
- R6: Clear (code 5) gives result 0 and sets Z, leaving N, OV, DC and C unchanged. On the status register this yields 000uu1uu.
- R7: Rotate left through carry (code 6) gives {f[6:0],C}, with C=f[7] and DC=f[3]. Rotate right (code 7) gives {C,f[7:1]}, with C=f[0] and DC=f[4]. Both update Z and N and keep OV.
- R8: Bit set (code 8) and bit clear (code 9) act on bit `acc_i[2:0]` of f, and nibble swap (code 10) exchanges the halves of f. None of them changes a flag. When they target the status register, they write the result's low five bits as data.
- R9: When a flag-affecting operation targets the status register, flags outside its affected set keep their old values. Those inside the set take the flag-logic value.
- R10: With `to_status_i` high, the source operand f is the current status value and `mem_i` is ignored. Otherwise f is `mem_i`.
- R11: With `wr_en_i` low, or with codes 12 to 15, neither `result_o` nor `status_o` changes.
- R12: Results and flags appear on the outputs one clock edge after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand, bit index for bit set and bit clear |
| mem_i | input | 8 | Data operand, used when the status register is not the target |
| to_status_i | input | 1 | The status register is source and destination |
| wr_en_i | input | 1 | Execute the operation this cycle |
| result_o | output | 8 | Registered operation result |
| status_o | output | 8 | Status value: three zero bits, then N, OV, Z, DC, C |

## Verification
Every result and flag is due exactly one rising edge after the operation is presented, because one register stage holds them. The bench drives each operation on a falling edge and compares both outputs on the next falling edge. At that point the edge in between has committed the outcome and the following operation has not yet been sampled. A bench model, built in integer arithmetic, carries the expected flags from one operation to the next. Checks of the unchanged-flag cases therefore depend on known flag patterns, which the bench loads through a move to the status register just before the operation under test.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;

  // flag positions inside the status register
  localparam int FL_C  = 0;
  localparam int FL_DC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_OV = 3;
  localparam int FL_N  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_CLR  = 4'd5,
    OP_RLC  = 4'd6,
    OP_RRC  = 4'd7,
    OP_BSET = 4'd8,
    OP_BCLR = 4'd9,
    OP_SWAP = 4'd10,
    OP_MOVE = 4'd11
  } op_e;

  // which flags an operation owns, ordered {N, OV, Z, DC, C}
  function automatic logic [FLAG_W-1:0] op_flag_mask(input logic [OP_W-1:0] op);
    case (op)
      OP_ADD, OP_SUB:          op_flag_mask = 5'b11111;
      OP_AND, OP_IOR, OP_XOR:  op_flag_mask = 5'b10100;
      OP_CLR:                  op_flag_mask = 5'b00100;
      OP_RLC, OP_RRC:          op_flag_mask = 5'b10111;
      default:                 op_flag_mask = 5'b00000;
    endcase
  endfunction

  // codes 12..15 are reserved and do nothing
  function automatic logic op_is_defined(input logic [OP_W-1:0] op);
    op_is_defined = (op <= OP_MOVE);
  endfunction

endpackage

// File: rtl/asu_datapath.sv
module asu_datapath
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] src,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] fval,
  output logic [FLAG_W-1:0] fmask,
  output logic              dest_we
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;
  localparam int IDX_W  = $clog2(DATA_W);

  logic              is_sub;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   full_sum;
  logic [HALF_W:0]   low_sum;
  logic              add_ov;
  logic [DATA_W-1:0] bit_mask;

  // subtraction adds the two's complement of the accumulator
  assign is_sub   = (op == OP_SUB);
  assign addend   = is_sub ? ~acc : acc;
  assign full_sum = {1'b0, src} + {1'b0, addend} + {{DATA_W{1'b0}}, is_sub};
  assign low_sum  = {1'b0, src[HALF_W-1:0]} + {1'b0, addend[HALF_W-1:0]}
                  + {{HALF_W{1'b0}}, is_sub};
  assign add_ov   = (src[MSB] == addend[MSB]) && (full_sum[MSB] != src[MSB]);
  assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << acc[IDX_W-1:0];

  assign fmask   = op_flag_mask(op);
  assign dest_we = op_is_defined(op);

  always_comb begin
    res         = src;
    fval        = '0;
    fval[FL_C]  = full_sum[DATA_W];
    fval[FL_DC] = low_sum[HALF_W];
    fval[FL_OV] = add_ov;
    case (op)
      OP_ADD, OP_SUB: res = full_sum[DATA_W-1:0];
      OP_AND:  res = src & acc;
      OP_IOR:  res = src | acc;
      OP_XOR:  res = src ^ acc;
      OP_CLR:  res = '0;
      OP_RLC: begin
        res         = {src[DATA_W-2:0], carry_in};
        fval[FL_C]  = src[MSB];
        fval[FL_DC] = src[HALF_W-1];
      end
      OP_RRC: begin
        res         = {carry_in, src[DATA_W-1:1]};
        fval[FL_C]  = src[0];
        fval[FL_DC] = src[HALF_W];
      end
      OP_BSET: res = src | bit_mask;
      OP_BCLR: res = src & ~bit_mask;
      OP_SWAP: res = {src[HALF_W-1:0], src[DATA_W-1:HALF_W]};
      OP_MOVE: res = acc;
      default: res = src;
    endcase
    fval[FL_Z] = (res == '0);
    fval[FL_N] = res[MSB];
  end

endmodule

// File: rtl/asu_flag_reg.sv
module asu_flag_reg
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic              dst_stat,
  input  logic              dest_we,
  input  logic [FLAG_W-1:0] fval,
  input  logic [FLAG_W-1:0] fmask,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] status
);

  localparam int PAD_W = DATA_W - FLAG_W;

  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  logic              any_flag;
  logic              data_wr;

  assign any_flag = |fmask;
  // a data write reaches the flags only if the operation owns none of them
  assign data_wr  = dst_stat && dest_we && !any_flag;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_comb begin
      if (fmask[i])     flags_d[i] = fval[i];
      else if (data_wr) flags_d[i] = data_in[i];
      else              flags_d[i] = flags_q[i];
    end
  end

  // flag bits power up undefined; only an executed operation loads them
  always_ff @(posedge clk) begin
    if (!rst && upd_en) flags_q <= flags_d;
  end

  assign status = {{PAD_W{1'b0}}, flags_q};

  assert_flag_logic_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_en && dst_stat && any_flag) |=>
      (((flags_q ^ $past(flags_q)) & ~$past(fmask)) == '0));

  assert_plain_data_write_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_en && data_wr) |=> (flags_q == $past(data_in[FLAG_W-1:0])));

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic              to_status_i,
  input  logic              wr_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] status_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] alu_res;
  logic [FLAG_W-1:0] alu_fval;
  logic [FLAG_W-1:0] alu_fmask;
  logic              alu_dest_we;
  logic [DATA_W-1:0] result_q;

  // the status register is the operand when it is also the target
  assign src = to_status_i ? status_o : mem_i;

  asu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op       (op_i),
    .acc      (acc_i),
    .src      (src),
    .carry_in (status_o[FL_C]),
    .res      (alu_res),
    .fval     (alu_fval),
    .fmask    (alu_fmask),
    .dest_we  (alu_dest_we)
  );

  asu_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (wr_en_i),
    .dst_stat (to_status_i),
    .dest_we  (alu_dest_we),
    .fval     (alu_fval),
    .fmask    (alu_fmask),
    .data_in  (alu_res),
    .status   (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                          result_q <= '0;
    else if (wr_en_i && alu_dest_we)  result_q <= alu_res;
  end

  assign result_o = result_q;

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i || !alu_dest_we) |=> ($stable(result_o) && $stable(status_o)));

  assert_zero_tracks_result_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && alu_fmask[FL_Z]) |=> (status_o[FL_Z] == (result_o == '0)));

  assert_neg_tracks_result_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && alu_fmask[FL_N]) |=> (status_o[FL_N] == result_o[MSB]));

  assert_upper_bits_zero_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (status_o[DATA_W-1:FLAG_W] == '0));

endmodule

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] mem_i = '0;
  logic       to_status_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] result_o;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;
  int exp_res = 0;
  int exp_fl = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_status_unit u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .mem_i(mem_i),
    .to_status_i(to_status_i), .wr_en_i(wr_en_i),
    .result_o(result_o), .status_o(status_o)
  );

  function automatic int sg(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // expected behaviour from the requirements, in integer arithmetic
  function automatic void model(input int op, input int a, input int b,
                                input bit dst, input bit we,
                                inout int res, inout int fl);
    int f, r, mask, s, c, dc, ov, full;
    bit wr;
    f = dst ? fl : b;
    if (!we) return;
    r = f; mask = 0; wr = 1; c = 0; dc = 0; ov = 0;
    case (op)
      0: begin s = f + a; r = s & 255; c = s > 255;
               dc = ((f & 15) + (a & 15)) > 15;
               s = sg(f) + sg(a); ov = (s > 127 || s < -128); mask = 31; end
      1: begin r = (f - a) & 255; c = f >= a; dc = (f & 15) >= (a & 15);
               s = sg(f) - sg(a); ov = (s > 127 || s < -128); mask = 31; end
      2: begin r = f & a; mask = 5'b10100; end
      3: begin r = f | a; mask = 5'b10100; end
      4: begin r = f ^ a; mask = 5'b10100; end
      5: begin r = 0; mask = 5'b00100; end
      6: begin r = ((f << 1) & 255) | (fl & 1); c = f >> 7; dc = (f >> 3) & 1;
               mask = 5'b10111; end
      7: begin r = (f >> 1) | ((fl & 1) << 7); c = f & 1; dc = (f >> 4) & 1;
               mask = 5'b10111; end
      8: r = f | (1 << (a & 7));
      9: r = f & ~(1 << (a & 7)) & 255;
      10: r = ((f & 15) << 4) | (f >> 4);
      11: r = a;
      default: wr = 0;
    endcase
    if (!wr) return;
    full = (r >= 128) * 16 + ov * 8 + (r == 0) * 4 + dc * 2 + c;
    fl = (fl & ~mask & 31) | (full & mask);
    if (dst && mask == 0) fl = r & 31;
    res = r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive on a falling edge, compare on the next falling edge (R12)
  task automatic step(input int op, input int a, input int b, input bit dst,
                      input bit we, input string req);
    model(op, a, b, dst, we, exp_res, exp_fl);
    op_i = op[3:0]; acc_i = a[7:0]; mem_i = b[7:0];
    to_status_i = dst; wr_en_i = we;
    @(negedge clk);
    chk({req, " result"}, int'(result_o), exp_res);
    chk({req, " status"}, int'(status_o), exp_fl);
  endtask

  task automatic preload(input int pat);
    step(11, pat, 8'h5A, 1'b1, 1'b1, "R2 preload");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset result", int'(result_o), 0);
    chk("R1 reset upper bits", int'(status_o[7:5]), 0);

    // R2 move to status, upper bits ignored (R1)
    step(11, 8'hFF, 0, 1'b1, 1'b1, "R1 R2 move ff to status");
    chk("R1 literal", int'(status_o), 8'h1F);
    step(11, 8'h3C, 8'h11, 1'b0, 1'b1, "R2 move no flags");

    // R3 / R4 literal corners
    step(0, 8'h01, 8'h7F, 1'b0, 1'b1, "R3 add 7f+1");
    chk("R3 literal", int'(status_o), 8'h1A);
    step(1, 8'h01, 8'h00, 1'b0, 1'b1, "R4 sub 0-1");
    chk("R4 literal", int'(status_o), 8'h10);

    // R3 / R4 sweep
    for (int f = 0; f < 256; f++) begin
      for (int j = 0; j < 36; j++) begin
        int a;
        a = (j < 32) ? ((j * 73) & 255) : ((j == 32) ? 255 : (j == 33) ? 128 : (j == 34) ? 127 : 1);
        step(0, a, f, 1'b0, 1'b1, "R3 add");
        step(1, a, f, 1'b0, 1'b1, "R4 sub");
      end
    end

    // R5 logical operations keep C, DC, OV
    for (int f = 0; f < 256; f++) begin
      for (int k = 2; k <= 4; k++) begin
        preload((f * 7) & 31);
        step(k, (f * 3 + 5) & 255, f, 1'b0, 1'b1, "R5 logic");
      end
    end

    // R7 rotates through carry, both carry inputs
    for (int f = 0; f < 256; f++) begin
      for (int cin = 0; cin < 2; cin++) begin
        preload(cin | 8);
        step(6, 0, f, 1'b0, 1'b1, "R7 rotate left");
        preload(cin | 8);
        step(7, 0, f, 1'b0, 1'b1, "R7 rotate right");
      end
    end

    // R6 clear, including on the status register
    preload(5'h1B);
    step(5, 0, 0, 1'b1, 1'b1, "R6 clear status");
    chk("R6 literal", int'(status_o), 8'h1F);
    preload(5'h00);
    step(5, 0, 0, 1'b1, 1'b1, "R6 clear status zero");
    chk("R6 literal zero", int'(status_o), 8'h04);
    preload(5'h13);
    step(5, 0, 8'h77, 1'b0, 1'b1, "R6 clear data");

    // R8 bit set / clear / swap, data and status targets
    for (int b = 0; b < 8; b++) begin
      preload(5'h0A);
      step(8, b, 8'h00, 1'b0, 1'b1, "R8 bit set");
      step(9, b, 8'hFF, 1'b0, 1'b1, "R8 bit clear");
      step(8, b, 0, 1'b1, 1'b1, "R8 bit set status");
      step(9, b, 0, 1'b1, 1'b1, "R8 bit clear status");
    end
    preload(5'h1C);
    step(10, 0, 0, 1'b1, 1'b1, "R8 swap status");
    step(10, 0, 8'hA5, 1'b0, 1'b1, "R8 swap data");

    // R9 / R10 flag operations on the status register
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 8; k++) begin
        if (k == 5) continue;
        preload(p);
        step(k, (p * 11 + 3) & 255, 8'hC3, 1'b1, 1'b1, "R9 R10 status operand");
      end
    end

    // R11 disabled cycles and reserved codes
    preload(5'h15);
    step(0, 8'h33, 8'h44, 1'b0, 1'b1, "R11 setup");
    for (int k = 0; k < 16; k++) begin
      step(k, 8'hFF, 8'h81, k[0], 1'b0, "R11 write disabled");
    end
    for (int k = 12; k < 16; k++) begin
      step(k, 8'h00, 8'h00, 1'b0, 1'b1, "R11 reserved code");
      step(k, 8'hFF, 8'hFF, 1'b1, 1'b1, "R11 reserved code status");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule